// File: doc/BRIEF.md
# SPI Host Interrupt Status and Enable Unit

This unit gathers single-cycle event pulses from an SPI host engine and its transmit and receive FIFOs and holds each one in a sticky status bit. Software clears status bits by writing ones to them, so it can write back a value it has just read and remove exactly the events it has seen. A per-source mask register and one global gate bit decide whether pending status drives the single level interrupt line towards the processor.

A status bit latches even while its source is masked. Software can therefore poll or acknowledge stale events before it opens the gate. The register port is a plain 32-bit write strobe with a byte address. Reads are combinational from the address. Addresses outside the three mapped registers read as zero and ignore writes.

Top module: `irq_ctrl`

## Requirements
- R1: The registers decode at byte address 0x1C (global gate), 0x20 (status) and 0x28 (mask). `rdata_o` follows `addr_i` combinationally.
- R2: Source bits on `event_i` and in the status and mask registers are: bit 0 mode fault, bit 1 slave-mode fault, bit 2 TX empty, bit 3 TX underrun, bit 4 RX full, bit 5 RX overrun, bit 6 TX half empty. A pulse on a source sets its status bit on the next clock edge, whatever the state of the mask.
- R3: A write to 0x20 clears each status bit whose write-data bit is 1. Bits written 0 keep their value.
- R4: If an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to 0x28 stores write-data bits [6:0] as the mask. Bits [31:7] read as zero.
- R6: A write to 0x1C stores only bit 31 as the global gate. All other bits of that register read as zero.
- R7: `irq_o` is a registered level. It is 1 exactly one cycle after a cycle in which the gate is 1 and some status bit is set with its mask bit also set.
- R8: An asynchronous active-low reset clears the gate, the mask, all status bits and `irq_o`.
- R9: A write to an unmapped address changes no register, and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| event_i | input | 7 | Single-cycle event pulses, one per source |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Level interrupt request |

## Verification
On every cycle, the assertions check that events latch, that ones written to the status register clear bits, that status and mask hold when nothing touches them, and that the line follows the gated, masked status one cycle later. The assertions also check that reset clears the status bits and the line. Only the bench scenarios show the address map and zero-filled read-back, the discarding of unmapped writes, and the same-cycle race between an event and its clear as seen through a read. The bench scenarios also show the one-cycle gap between opening the gate and the line rising, and an asynchronous reset in the middle of activity.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned GATE_BIT = 31;

  localparam logic [ADDR_W-1:0] OFF_GATE   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h28;

  typedef struct packed {
    logic gate;
    logic status;
    logic mask;
  } reg_sel_t;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_t          sel_o
);
  always_comb begin
    sel_o        = '0;
    sel_o.gate   = (addr_i == OFF_GATE);
    sel_o.status = (addr_i == OFF_STATUS);
    sel_o.mask   = (addr_i == OFF_MASK);
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] clr_mask_i,
  output logic [NUM_SRC-1:0] status_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          bit_q <= 1'b0;
      else if (event_i[i])  bit_q <= 1'b1;  // set beats clear
      else if (clr_we_i && clr_mask_i[i]) bit_q <= 1'b0;
    end
    assign status_o[i] = bit_q;
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic               gate_i,
  output logic               irq_o
);
  logic irq_d;
  assign irq_d = gate_i && |(status_i & mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= irq_d;
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  reg_sel_t           sel;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] mask_q;
  logic               gate_q;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i;

  irq_reg_decode u_decode (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  irq_status_bank #(.NUM_SRC(NUM_SRC)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .event_i    (event_i),
    .clr_we_i   (we_i && sel.status),
    .clr_mask_i (wdata_i[NUM_SRC-1:0]),
    .status_o   (status_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      gate_q <= 1'b0;
    end else if (we_i) begin
      if (sel.mask) mask_q <= wdata_i[NUM_SRC-1:0];
      if (sel.gate) gate_q <= wdata_i[GATE_BIT];
    end
  end

  irq_out_stage #(.NUM_SRC(NUM_SRC)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_q),
    .mask_i   (mask_q),
    .gate_i   (gate_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (sel.gate)   rdata_o[GATE_BIT]    = gate_q;
    if (sel.status) rdata_o[NUM_SRC-1:0] = status_q;
    if (sel.mask)   rdata_o[NUM_SRC-1:0] = mask_q;
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned N = 7
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] event_i,
  input logic         wr_status_i,
  input logic         wr_mask_i,
  input logic [N-1:0] wdata_lo_i,
  input logic [N-1:0] status_q,
  input logic [N-1:0] mask_q,
  input logic         gate_q,
  input logic         irq_o
);
  a_r2_event_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i != '0) |=> ((status_q & $past(event_i)) == $past(event_i)));

  a_r3_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_status_i |=> ((status_q & $past(wdata_lo_i) & ~$past(event_i)) == '0));

  a_r3_status_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i == '0 && !wr_status_i) |=> $stable(status_q));

  a_r5_mask_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask_i |=> $stable(mask_q));

  a_r7_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(gate_q && ((status_q & mask_q) != '0))));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r8_reset_clear: assert (status_q == '0 && mask_q == '0 && !gate_q && !irq_o);
    end
  end
endmodule

bind irq_ctrl irq_ctrl_chk #(.N(NUM_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .event_i     (event_i),
  .wr_status_i (we_i && (addr_i == irq_pkg::OFF_STATUS)),
  .wr_mask_i   (we_i && (addr_i == irq_pkg::OFF_MASK)),
  .wdata_lo_i  (wdata_i[NUM_SRC-1:0]),
  .status_q    (status_q),
  .mask_q      (mask_q),
  .gate_q      (gate_q),
  .irq_o       (irq_o)
);

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_GATE = 8'h1C, A_STAT = 8'h20, A_MASK = 8'h28;
  // {event[6:0], mask[6:0], gate, expected irq}
  localparam logic [15:0] VEC [8] = '{
    {7'h01, 7'h01, 1'b1, 1'b1},
    {7'h02, 7'h01, 1'b1, 1'b0},
    {7'h40, 7'h7F, 1'b0, 1'b0},
    {7'h7F, 7'h00, 1'b1, 1'b0},
    {7'h10, 7'h30, 1'b1, 1'b1},
    {7'h28, 7'h08, 1'b1, 1'b1},
    {7'h04, 7'h7B, 1'b1, 1'b0},
    {7'h60, 7'h40, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic [6:0]  event_i = '0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] rd_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .event_i(event_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a; #1 d = rdata_o;
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk); event_i = e;
    @(negedge clk); event_i = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rd(A_STAT, rd_val); chk("R8 status after reset", rd_val, 0);
    rd(A_MASK, rd_val); chk("R8 mask after reset", rd_val, 0);
    rd(A_GATE, rd_val); chk("R8 gate after reset", rd_val, 0);
    chk("R8 irq after reset", {31'b0, irq_o}, 0);
    rst_ni = 1'b1;

    // table walk: R2 latch regardless of mask, R7 gating
    for (int i = 0; i < 8; i++) begin
      wr(A_STAT, 32'h7F);
      wr(A_MASK, {25'b0, VEC[i][8:2]});
      wr(A_GATE, {VEC[i][1], 31'b0});
      pulse(VEC[i][15:9]);
      @(negedge clk);
      rd(A_STAT, rd_val); chk("R2 latched status", rd_val, {25'b0, VEC[i][15:9]});
      chk("R7 irq level", {31'b0, irq_o}, {31'b0, VEC[i][0]});
    end

    // R3 partial clear
    wr(A_STAT, 32'h7F); wr(A_GATE, 0);
    pulse(7'h15);
    wr(A_STAT, 32'h0000_0001);
    rd(A_STAT, rd_val); chk("R3 partial clear", rd_val, 32'h14);

    // R4 event beats same-cycle clear
    @(negedge clk); we_i = 1'b1; addr_i = A_STAT; wdata_i = 32'h14; event_i = 7'h04;
    @(negedge clk); we_i = 1'b0; wdata_i = '0; event_i = '0;
    rd(A_STAT, rd_val); chk("R4 event wins", rd_val, 32'h04);

    // R5 / R6 / R1 field widths
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK, rd_val); chk("R5 mask width", rd_val, 32'h7F);
    wr(A_GATE, 32'hFFFF_FFFF);
    rd(A_GATE, rd_val); chk("R6 gate bit only", rd_val, 32'h8000_0000);
    wr(A_GATE, 32'h7FFF_FFFF);
    rd(A_GATE, rd_val); chk("R6 low bits ignored", rd_val, 0);

    // R9 unmapped write/read
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, rd_val); chk("R9 unmapped read", rd_val, 0);
    rd(A_STAT, rd_val); chk("R9 status untouched", rd_val, 32'h04);
    rd(A_MASK, rd_val); chk("R9 mask untouched", rd_val, 32'h7F);
    rd(A_GATE, rd_val); chk("R1 gate offset readback", rd_val, 0);

    // R7 latency after opening gate
    @(negedge clk);
    chk("R7 gate closed", {31'b0, irq_o}, 0);
    wr(A_GATE, 32'h8000_0000);
    chk("R7 one-cycle latency", {31'b0, irq_o}, 0);
    @(negedge clk);
    chk("R7 irq rises", {31'b0, irq_o}, 1);

    // R8 asynchronous reset mid-run
    #1 rst_ni = 1'b0;
    #1;
    chk("R8 async irq clear", {31'b0, irq_o}, 0);
    rd(A_STAT, rd_val); chk("R8 async status clear", rd_val, 0);
    rd(A_MASK, rd_val); chk("R8 async mask clear", rd_val, 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule